// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a 16-bit virtual address space split into 4 KB pages. The upper 4 bits of an address select the virtual page. The lower 12 bits are the offset within the page. Physical memory is 32 KB, so a physical page holds a 3-bit number and a physical address is 15 bits wide. The buffer has eight entries. A strobed request compares its page number against every entry at once. One clock later the block reports exactly one result:

- a hit, together with the translated address;
- a miss, when no valid entry carries that page;
- a protection fault, when an entry matches but does not permit the requested read or write.

A fault is never counted as a hit.

After a miss, an external table walker returns the missing translation on the refill port. The block chooses where the translation goes:

- If the page is already resident, that entry is overwritten.
- Otherwise the lowest-numbered empty entry is used.
- Otherwise a rotating pointer names the entry to evict.

A flush input empties the whole buffer in one cycle, for use after a change of address space.

Top module: `xlat_buffer`

## Requirements
- R1: The page number is address bits [15:12] and the offset is bits [11:0]. On a hit, rsp_paddr equals {stored 3-bit frame, unchanged 12-bit offset}.
- R2: rsp_valid is high in exactly the cycle after req_valid was sampled high. In any cycle without rsp_valid, rsp_hit, rsp_miss and rsp_fault are all low.
- R3: Whenever rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is high.
- R4: A hit requires a valid entry whose tag equals the page number and whose permission allows the access. A read (req_write=0) needs the read-permission bit. A write (req_write=1) needs the write-permission bit.
- R5: A valid matching entry whose permission forbids the access gives rsp_fault, not rsp_hit, with rsp_paddr zero.
- R6: With no valid matching entry the result is rsp_miss with rsp_paddr zero.
- R7: A refill sampled at a clock edge is visible to any request sampled at a later edge. A request sampled at the same edge as a refill or flush sees the contents from before that edge.
- R8: A refill whose page is already resident overwrites that entry. No other entry changes, and the eviction pointer does not move.
- R9: A refill of a non-resident page goes to the lowest-numbered invalid entry when one exists, and the pointer does not move.
- R10: When all entries are valid, a refill of a non-resident page evicts the entry named by the rotating pointer. The pointer is 0 after reset and advances by one, modulo 8, after each such eviction.
- R11: flush clears every valid bit in one cycle. It wins over a refill in the same cycle, which is dropped. It does not move the pointer.
- R12: After reset no entry is valid and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid entry for the page |
| rsp_fault | output | 1 | Entry found, access not permitted |
| rsp_paddr | output | 15 | Physical address on a hit, else zero |
| fill_valid | input | 1 | Refill strobe from the table walker |
| fill_vpn | input | 4 | Page number of the refill |
| fill_pfn | input | 3 | Physical frame of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |

## Verification
Every lookup result is registered, so it is due one clock after the edge that samples the request. The bench drives inputs on the falling edge and reads results on the next falling edge, after exactly one rising edge. A refill or flush changes the contents at the edge that samples it, so each check of its effect uses a lookup issued at the following falling edge. The victim rules are observed only through later hits and misses: the pointer position is inferred from which resident page stops hitting after each eviction.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W        = 16;
  localparam int OFS_W       = 12;
  localparam int PA_W        = 15;
  localparam int NUM_ENTRIES = 8;
  localparam int VPN_W       = VA_W - OFS_W;
  localparam int PFN_W       = PA_W - OFS_W;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] tag;
    logic [PFN_W-1:0] pfn;
    logic             can_rd;
    logic             can_wr;
  } xlat_entry_t;
endpackage

// File: rtl/xlat_entry_bank.sv
module xlat_entry_bank
  import xlat_pkg::*;
#(
  parameter int N     = NUM_ENTRIES,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  xlat_entry_t           wr_entry,
  output xlat_entry_t [N-1:0]   ent_q
);
  xlat_entry_t [N-1:0] ent_d;
  logic                upd_en;

  // Flush has priority over a write in the same cycle.
  always_comb begin
    ent_d = ent_q;
    if (flush) begin
      for (int i = 0; i < N; i++) ent_d[i].vld = 1'b0;
    end else if (wr_en) begin
      ent_d[wr_idx] = wr_entry;
    end
  end

  assign upd_en = flush | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (upd_en) ent_q <= ent_d;
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int N     = NUM_ENTRIES,
  parameter int IDX_W = $clog2(N)
) (
  input  xlat_entry_t [N-1:0] ent,
  input  logic [VPN_W-1:0]    vpn,
  output logic                any_hit,
  output logic [IDX_W-1:0]    hit_idx,
  output xlat_entry_t         hit_ent
);
  logic [N-1:0] hit_vec;

  // One comparator per entry, all evaluated in parallel.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent[g].vld && (ent[g].tag == vpn);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_ent = ent[hit_idx];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int N     = NUM_ENTRIES,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xlat_entry_t [N-1:0] ent,
  input  logic                fill_valid,
  input  logic                flush,
  input  logic                tag_hit,
  input  logic [IDX_W-1:0]    tag_idx,
  output logic [IDX_W-1:0]    vic_idx
);
  logic [N-1:0]     free_vec;
  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  for (genvar g = 0; g < N; g++) begin : g_free
    assign free_vec[g] = ~ent[g].vld;
  end

  assign any_free = |free_vec;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  // Priority: same tag, then lowest free slot, then the rotating pointer.
  always_comb begin
    if (tag_hit)       vic_idx = tag_idx;
    else if (any_free) vic_idx = free_idx;
    else               vic_idx = ptr_q;
  end

  assign ptr_en = fill_valid & ~flush & ~tag_hit & ~any_free;
  assign ptr_d  = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_rd,
  input  logic             fill_wr
);
  localparam int N     = NUM_ENTRIES;
  localparam int IDX_W = $clog2(N);

  xlat_entry_t [N-1:0] ent;
  xlat_entry_t         lk_ent, fl_ent, new_ent;
  logic                lk_any, fl_any;
  logic [IDX_W-1:0]    lk_idx, fl_idx, vic_idx;
  logic                perm_ok;
  logic                wr_en;
  logic                val_d, hit_d, miss_d, fault_d;
  logic [PA_W-1:0]     paddr_d;

  xlat_entry_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .wr_idx(vic_idx), .wr_entry(new_ent), .ent_q(ent)
  );

  // Lookup port.
  xlat_match #(.N(N)) u_lk_match (
    .ent(ent), .vpn(req_vaddr[VA_W-1:OFS_W]),
    .any_hit(lk_any), .hit_idx(lk_idx), .hit_ent(lk_ent)
  );

  // Refill port: finds an already resident copy of the page.
  xlat_match #(.N(N)) u_fl_match (
    .ent(ent), .vpn(fill_vpn),
    .any_hit(fl_any), .hit_idx(fl_idx), .hit_ent(fl_ent)
  );

  xlat_victim #(.N(N)) u_victim (
    .clk(clk), .rst_n(rst_n), .ent(ent), .fill_valid(fill_valid),
    .flush(flush), .tag_hit(fl_any), .tag_idx(fl_idx), .vic_idx(vic_idx)
  );

  assign wr_en = fill_valid & ~flush;

  always_comb begin
    new_ent        = '0;
    new_ent.vld    = 1'b1;
    new_ent.tag    = fill_vpn;
    new_ent.pfn    = fill_pfn;
    new_ent.can_rd = fill_rd;
    new_ent.can_wr = fill_wr;
  end

  // Result next state.
  assign perm_ok = req_write ? lk_ent.can_wr : lk_ent.can_rd;

  always_comb begin
    val_d   = req_valid;
    hit_d   = req_valid & lk_any & perm_ok;
    fault_d = req_valid & lk_any & ~perm_ok;
    miss_d  = req_valid & ~lk_any;
    paddr_d = hit_d ? {lk_ent.pfn, req_vaddr[OFS_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= val_d;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end

  // Unused fields of the refill-port match result.
  logic unused_fl;
  assign unused_fl = ^fl_ent;
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk
  import xlat_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr
);
  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_follows_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  a_r3_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  a_r6_miss_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_paddr == '0);

  a_r11_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_valid |=> rsp_miss);
endmodule

bind xlat_buffer xlat_buffer_chk u_chk (.*);

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid, req_write;
  logic [15:0] req_vaddr;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [14:0] rsp_paddr;
  logic        fill_valid, fill_rd, fill_wr;
  logic [3:0]  fill_vpn;
  logic [2:0]  fill_pfn;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_buffer uut (.*);

  // Result codes used in the table: 0 hit, 1 miss, 2 fault.
  // Vector layout: {vaddr[15:0], write, code[1:0], paddr[14:0]}.
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {16'h0ABC, 1'b0, 2'd0, 15'h5ABC},
    {16'h0123, 1'b1, 2'd0, 15'h5123},
    {16'h1FFF, 1'b0, 2'd0, 15'h2FFF},
    {16'h1000, 1'b1, 2'd2, 15'h0000},
    {16'h2345, 1'b0, 2'd2, 15'h0000},
    {16'h2345, 1'b1, 2'd0, 15'h7345},
    {16'h3000, 1'b0, 2'd0, 15'h0000},
    {16'h4FFF, 1'b1, 2'd0, 15'h3FFF},
    {16'h5010, 1'b0, 2'd2, 15'h0000},
    {16'h5010, 1'b1, 2'd2, 15'h0000},
    {16'h6777, 1'b0, 2'd0, 15'h1777},
    {16'h7001, 1'b1, 2'd2, 15'h0000},
    {16'h7001, 1'b0, 2'd0, 15'h4001},
    {16'h8000, 1'b0, 2'd1, 15'h0000},
    {16'hF123, 1'b1, 2'd1, 15'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [3:0] vpn, input logic [2:0] pfn,
                      input logic rd, input logic wr, input logic fl);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
    fill_rd = rd; fill_wr = wr; flush = fl;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
  endtask

  // Lookup: drive at a falling edge, read one rising edge later.
  task automatic lookup(input string req, input logic [15:0] va, input logic wr,
                        input logic [1:0] code, input logic [14:0] pa);
    logic [2:0] exp_flags;
    exp_flags = (code == 2'd0) ? 3'b100 : (code == 2'd1) ? 3'b010 : 3'b001;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {31'd0, rsp_valid}, 32'd1);
    chk(req, {29'd0, rsp_hit, rsp_miss, rsp_fault}, {29'd0, exp_flags});
    chk(req, {17'd0, rsp_paddr}, {17'd0, pa});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_rd = 1'b0; fill_wr = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
    chk("R12", {17'd0, rsp_paddr}, 32'd0);
    rst_n = 1'b1;
    lookup("R12", 16'h0000, 1'b0, 2'd1, 15'h0);

    // R9: empty buffer fills slots in order, nothing evicted
    fill(4'h0, 3'd5, 1'b1, 1'b1, 1'b0);
    fill(4'h1, 3'd2, 1'b1, 1'b0, 1'b0);
    fill(4'h2, 3'd7, 1'b0, 1'b1, 1'b0);
    fill(4'h3, 3'd0, 1'b1, 1'b1, 1'b0);
    fill(4'h4, 3'd3, 1'b1, 1'b1, 1'b0);
    fill(4'h5, 3'd6, 1'b0, 1'b0, 1'b0);
    fill(4'h6, 3'd1, 1'b1, 1'b1, 1'b0);
    fill(4'h7, 3'd4, 1'b1, 1'b0, 1'b0);

    // R1 R4 R5 R6: table of lookups
    for (int k = 0; k < NV; k++) begin
      lookup("R1_R4_R5_R6_R9", VEC[k][33:18], VEC[k][17], VEC[k][16:15], VEC[k][14:0]);
    end

    // R2: no strobe gives no result
    @(negedge clk);
    chk("R2", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'd0);

    // R7 R10: full buffer, pointer at 0 evicts page 0
    fill(4'h8, 3'd3, 1'b1, 1'b1, 1'b0);
    lookup("R7", 16'h8004, 1'b0, 2'd0, 15'h3004);
    lookup("R10", 16'h0004, 1'b0, 2'd1, 15'h0);
    fill(4'h9, 3'd6, 1'b1, 1'b0, 1'b0);
    lookup("R10", 16'h9000, 1'b0, 2'd0, 15'h6000);
    lookup("R10", 16'h1000, 1'b0, 2'd1, 15'h0);

    // R8: resident page overwritten in place, pointer unmoved
    fill(4'h2, 3'd4, 1'b1, 1'b1, 1'b0);
    lookup("R8", 16'h2010, 1'b0, 2'd0, 15'h4010);
    lookup("R8", 16'h3010, 1'b0, 2'd0, 15'h0010);
    lookup("R8", 16'h8004, 1'b1, 2'd0, 15'h3004);
    fill(4'hA, 3'd2, 1'b1, 1'b1, 1'b0);
    lookup("R8", 16'h2010, 1'b0, 2'd1, 15'h0);
    lookup("R8", 16'h3010, 1'b0, 2'd0, 15'h0010);
    lookup("R10", 16'hA000, 1'b1, 2'd0, 15'h2000);

    // R11: flush with a simultaneous refill; refill dropped
    fill(4'hB, 3'd1, 1'b1, 1'b1, 1'b1);
    lookup("R11", 16'hB000, 1'b0, 2'd1, 15'h0);
    lookup("R11", 16'h3010, 1'b0, 2'd1, 15'h0);
    lookup("R11", 16'hA000, 1'b1, 2'd1, 15'h0);

    // R9 after flush: eight refills all stay resident
    for (int v = 15; v >= 8; v--) fill(4'(v), 3'(v - 8), 1'b1, 1'b1, 1'b0);
    for (int v = 8; v <= 15; v++)
      lookup("R9", {4'(v), 12'h055}, 1'b0, 2'd0, {3'(v - 8), 12'h055});

    // R10 R11: pointer kept at 3 through flush, slot 3 holds page C
    fill(4'h0, 3'd7, 1'b1, 1'b1, 1'b0);
    lookup("R10", 16'hC055, 1'b0, 2'd1, 15'h0);
    lookup("R10", 16'h0055, 1'b0, 2'd0, 15'h7055);
    lookup("R10", 16'hB055, 1'b0, 2'd0, 15'h3055);
    lookup("R10", 16'hD055, 1'b1, 2'd0, 15'h5055);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule